// File: doc/BRIEF.md
# Banked Program Memory Mapper

This block sits between a CPU and the program ROM and work RAM of a cartridge bank-switching controller. It takes every CPU address from 0x6000 up to 0xFFFF and produces a banked ROM address, a ROM chip enable, a RAM chip enable and a flag marking reads that nothing answers (open bus). The ROM is seen as four 8 KiB windows. The window at 0xE000 always shows the last bank of the ROM. The window at 0xA000 always shows the bank in the second select register. Either the window at 0x8000 or the one at 0xC000 follows the first select register, and the other one shows the second-last bank. A swap bit chooses which.

Software sets up the mapper by writing into the 0x8000–0xFFFF range. Each 4 KiB group in that range holds four register slots. Two CPU address lines, fixed per board by parameters, form the slot index. A control slot holds the swap bit and a bit that lets the work RAM page at 0x6000–0x7FFF through. When that bit is clear, accesses to the page go to no memory at all. A write to a further slot pulses an active-low strobe for extra hardware outside the block. The block has no states of its own: there are registers that writes load, and translation logic that depends only on them and on the current address.

Top module: `banked_prg_mapper`

## Requirements
- R1: After reset both bank selects, the swap bit and the RAM enable are 0. A read at 0x8000 therefore gives bank 0, a read at 0xC000 gives bank ROM_BANKS-2, and a read at 0x6000 is flagged open bus.
- R2: A write anywhere in 0xA000–0xAFFF loads data bits 4:0 into the second select. Reads in 0xA000–0xBFFF then give rom_addr = {select, cpu_addr[12:0]}.
- R3: A write anywhere in 0x8000–0x8FFF loads data bits 4:0 into the first select. With swap clear, the 0x8000 window uses that select and the 0xC000 window uses bank ROM_BANKS-2.
- R4: With swap set, the 0x8000 window uses bank ROM_BANKS-2 and the 0xC000 window uses the first select.
- R5: Reads in 0xE000–0xFFFF always give bank ROM_BANKS-1.
- R6: A write in 0x9000–0x9FFF whose slot index is 2 sets RAM enable from data bit 0 and swap from data bit 1. A write to any other slot of that group leaves both unchanged.
- R7: With RAM enable clear, an access to 0x6000–0x7FFF keeps ram_ce low, and a read there raises open_bus. With RAM enable set, ram_ce is high for reads and writes there and open_bus stays low.
- R8: The slot index is {cpu_addr[IDX_HI_BIT], cpu_addr[IDX_LO_BIT]}, where the two bit numbers are parameters.
- R9: A write sampled at a clock edge to slot 3 of the 0x9000 group drives ext_sel_n low for the following cycle. At every other time ext_sel_n is high.
- R10: Registers load only at a rising edge with cpu_wr high. The bank used is the select value taken modulo ROM_BANKS.
- R11: rom_ce is high only for reads (cpu_wr low) in 0x8000–0xFFFF. Outside the four ROM windows, rom_addr carries bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write qualifier, high for a write cycle |
| rom_addr | output | ROM_AW (18) | Banked ROM byte address |
| rom_ce | output | 1 | ROM chip enable for reads of 0x8000–0xFFFF |
| ram_ce | output | 1 | Work RAM chip enable for 0x6000–0x7FFF |
| open_bus | output | 1 | High when a read is answered by no memory |
| ext_sel_n | output | 1 | Active-low one-cycle strobe for a write to the external slot |

## Verification
On every cycle the assertions check four things: which fixed bank the 0x8000, 0xC000 and 0xE000 windows show for the current swap setting, that the RAM enable and open-bus outputs respect the RAM gate, that the control bits change only after a control-slot write, and that the strobe follows each external-slot write. Whether the switchable windows show the value that was last written, whether high data bits are dropped, and whether a second set of index lines decodes correctly can only be shown by the bench, which writes known values and reads them back through the windows. The bench also brings out the reset state and the effect of writes to the wrong slot by reading at the addresses those registers control.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int SEL_W = 5;   // stored bits of each bank select
    localparam int OFF_W = 13;  // byte offset inside an 8 KiB page

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_RAM,
        WIN_LO,
        WIN_MID,
        WIN_HI,
        WIN_TOP
    } win_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel_lo;
        logic [SEL_W-1:0] sel_mid;
        logic             swap;
        logic             ram_en;
    } map_cfg_t;

    function automatic win_e win_of(input logic [2:0] page);
        case (page)
            3'b011:  return WIN_RAM;
            3'b100:  return WIN_LO;
            3'b101:  return WIN_MID;
            3'b110:  return WIN_HI;
            3'b111:  return WIN_TOP;
            default: return WIN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/prg_map_decode.sv
module prg_map_decode #(
    parameter int IDX_LO_BIT = 0,
    parameter int IDX_HI_BIT = 1
) (
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    output logic        hit_sel_lo,
    output logic        hit_sel_mid,
    output logic        hit_ctrl,
    output logic        hit_ext
);

    logic [1:0] slot;
    logic       reg_wr;
    logic       unused_addr;

    generate
        if (IDX_LO_BIT == IDX_HI_BIT || IDX_LO_BIT > 11 || IDX_HI_BIT > 11) begin : g_bad_idx
            initial $error("slot index lines must be two distinct bits below 12");
        end
    endgenerate

    assign slot        = {cpu_addr[IDX_HI_BIT], cpu_addr[IDX_LO_BIT]};
    assign reg_wr      = cpu_wr && cpu_addr[15];
    assign unused_addr = ^cpu_addr[11:0];

    always_comb begin
        hit_sel_lo  = 1'b0;
        hit_sel_mid = 1'b0;
        hit_ctrl    = 1'b0;
        hit_ext     = 1'b0;
        if (reg_wr) begin
            unique case (cpu_addr[14:12])
                3'b000:  hit_sel_lo  = 1'b1;
                3'b010:  hit_sel_mid = 1'b1;
                3'b001: begin
                    hit_ctrl = (slot == 2'd2);
                    hit_ext  = (slot == 2'd3);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/prg_map_regs.sv
module prg_map_regs
    import prg_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cpu_data,
    input  logic       hit_sel_lo,
    input  logic       hit_sel_mid,
    input  logic       hit_ctrl,
    input  logic       hit_ext,
    output map_cfg_t   cfg,
    output logic       ext_sel_n
);

    logic unused_data;
    assign unused_data = ^cpu_data[7:SEL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            ext_sel_n <= 1'b1;
        end else begin
            ext_sel_n <= !hit_ext;
            if (hit_sel_lo)  cfg.sel_lo  <= cpu_data[SEL_W-1:0];
            if (hit_sel_mid) cfg.sel_mid <= cpu_data[SEL_W-1:0];
            if (hit_ctrl) begin
                cfg.ram_en <= cpu_data[0];
                cfg.swap   <= cpu_data[1];
            end
        end
    end

endmodule

// File: rtl/prg_map_xlate.sv
module prg_map_xlate
    import prg_map_pkg::*;
#(
    parameter  int ROM_BANKS = 32,
    localparam int BANK_W    = $clog2(ROM_BANKS),
    localparam int ROM_AW    = BANK_W + OFF_W
) (
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    input  map_cfg_t          cfg,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce,
    output logic              ram_ce,
    output logic              open_bus
);

    localparam logic [BANK_W-1:0] LAST_BANK   = BANK_W'(ROM_BANKS - 1);
    localparam logic [BANK_W-1:0] SECOND_BANK = BANK_W'(ROM_BANKS - 2);

    win_e              win;
    logic [BANK_W-1:0] bank;
    logic [BANK_W-1:0] lo_bank;
    logic [BANK_W-1:0] mid_bank;

    generate
        if (BANK_W > SEL_W || ROM_BANKS < 2 || (1 << BANK_W) != ROM_BANKS) begin : g_bad_size
            initial $error("ROM_BANKS must be a power of two from 2 to 32");
        end
        if (BANK_W < SEL_W) begin : g_narrow
            logic unused_sel;
            assign unused_sel = ^{cfg.sel_lo[SEL_W-1:BANK_W], cfg.sel_mid[SEL_W-1:BANK_W]};
        end
    endgenerate

    assign win      = win_of(cpu_addr[15:13]);
    assign lo_bank  = cfg.sel_lo[BANK_W-1:0];
    assign mid_bank = cfg.sel_mid[BANK_W-1:0];

    always_comb begin
        bank     = '0;
        rom_ce   = 1'b0;
        ram_ce   = 1'b0;
        open_bus = 1'b0;
        unique case (win)
            WIN_RAM: begin
                ram_ce   = cfg.ram_en;
                open_bus = !cfg.ram_en && !cpu_wr;
            end
            WIN_LO: begin
                bank   = cfg.swap ? SECOND_BANK : lo_bank;
                rom_ce = !cpu_wr;
            end
            WIN_MID: begin
                bank   = mid_bank;
                rom_ce = !cpu_wr;
            end
            WIN_HI: begin
                bank   = cfg.swap ? lo_bank : SECOND_BANK;
                rom_ce = !cpu_wr;
            end
            WIN_TOP: begin
                bank   = LAST_BANK;
                rom_ce = !cpu_wr;
            end
            WIN_NONE: ;
        endcase
    end

    assign rom_addr = {bank, cpu_addr[OFF_W-1:0]};

endmodule

// File: rtl/banked_prg_mapper.sv
module banked_prg_mapper
    import prg_map_pkg::*;
#(
    parameter  int ROM_BANKS  = 32,
    parameter  int IDX_LO_BIT = 0,
    parameter  int IDX_HI_BIT = 1,
    localparam int BANK_W     = $clog2(ROM_BANKS),
    localparam int ROM_AW     = BANK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce,
    output logic              ram_ce,
    output logic              open_bus,
    output logic              ext_sel_n
);

    logic     hit_sel_lo;
    logic     hit_sel_mid;
    logic     hit_ctrl;
    logic     hit_ext;
    map_cfg_t cfg;
    logic     swap_mode;
    logic     ram_en;

    prg_map_decode #(
        .IDX_LO_BIT (IDX_LO_BIT),
        .IDX_HI_BIT (IDX_HI_BIT)
    ) u_decode (
        .cpu_addr    (cpu_addr),
        .cpu_wr      (cpu_wr),
        .hit_sel_lo  (hit_sel_lo),
        .hit_sel_mid (hit_sel_mid),
        .hit_ctrl    (hit_ctrl),
        .hit_ext     (hit_ext)
    );

    prg_map_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_data    (cpu_data),
        .hit_sel_lo  (hit_sel_lo),
        .hit_sel_mid (hit_sel_mid),
        .hit_ctrl    (hit_ctrl),
        .hit_ext     (hit_ext),
        .cfg         (cfg),
        .ext_sel_n   (ext_sel_n)
    );

    prg_map_xlate #(
        .ROM_BANKS (ROM_BANKS)
    ) u_xlate (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cfg      (cfg),
        .rom_addr (rom_addr),
        .rom_ce   (rom_ce),
        .ram_ce   (ram_ce),
        .open_bus (open_bus)
    );

    assign swap_mode = cfg.swap;
    assign ram_en    = cfg.ram_en;

endmodule

// File: rtl/prg_mapper_chk.sv
module prg_mapper_chk #(
    parameter  int ROM_BANKS  = 32,
    parameter  int IDX_LO_BIT = 0,
    parameter  int IDX_HI_BIT = 1,
    localparam int BANK_W     = $clog2(ROM_BANKS),
    localparam int ROM_AW     = BANK_W + 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_wr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_ce,
    input logic              ram_ce,
    input logic              open_bus,
    input logic              ext_sel_n,
    input logic              swap_mode,
    input logic              ram_en
);

    localparam logic [BANK_W-1:0] LAST_BANK   = BANK_W'(ROM_BANKS - 1);
    localparam logic [BANK_W-1:0] SECOND_BANK = BANK_W'(ROM_BANKS - 2);

    logic [1:0] slot;
    logic       rd;
    logic       ctrl_wr;
    logic       ext_wr;

    assign slot    = {cpu_addr[IDX_HI_BIT], cpu_addr[IDX_LO_BIT]};
    assign rd      = !cpu_wr;
    assign ctrl_wr = cpu_wr && cpu_addr[15:12] == 4'h9 && slot == 2'd2;
    assign ext_wr  = cpu_wr && cpu_addr[15:12] == 4'h9 && slot == 2'd3;

    assert_noswap_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_mode && rd && cpu_addr[15:13] == 3'b110) |-> rom_addr[ROM_AW-1:13] == SECOND_BANK);

    assert_swap_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_mode && rd && cpu_addr[15:13] == 3'b100) |-> rom_addr[ROM_AW-1:13] == SECOND_BANK);

    assert_last_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cpu_addr[15:13] == 3'b111) |-> (rom_ce && rom_addr[ROM_AW-1:13] == LAST_BANK));

    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ($stable(swap_mode) && $stable(ram_en)));

    assert_ram_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> (ram_en && cpu_addr[15:13] == 3'b011 && !open_bus));

    assert_open_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (!ram_en && rd));

    assert_strobe_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |=> !ext_sel_n);

    assert_strobe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr |=> ext_sel_n);

    assert_rom_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce |-> (rd && cpu_addr[15]));

endmodule

bind banked_prg_mapper prg_mapper_chk #(
    .ROM_BANKS  (ROM_BANKS),
    .IDX_LO_BIT (IDX_LO_BIT),
    .IDX_HI_BIT (IDX_HI_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .rom_addr  (rom_addr),
    .rom_ce    (rom_ce),
    .ram_ce    (ram_ce),
    .open_bus  (open_bus),
    .ext_sel_n (ext_sel_n),
    .swap_mode (swap_mode),
    .ram_en    (ram_en)
);

// File: tb/sim_banked_prg_mapper.sv
module sim_banked_prg_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 26;

    typedef struct packed {
        logic        is_wr;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [17:0] exp_addr;
        logic        exp_rom;
        logic        exp_ram;
        logic        exp_ob;
        logic [3:0]  req;
    } vec_t;

    // Default instance: 32 banks, last = 31, second-last = 30
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 16'h8000, 8'h00, 18'h00000, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b0, 16'hC010, 8'h00, 18'h3C010, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 16'h6000, 8'h00, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd1},  // R1
        '{1'b1, 16'h8000, 8'h05, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b0, 16'h8123, 8'h00, 18'h0A123, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 16'hA001, 8'hE7, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b0, 16'hBFFF, 8'h00, 18'h0FFFF, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b0, 16'hE000, 8'h00, 18'h3E000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        '{1'b0, 16'hFFFF, 8'h00, 18'h3FFFF, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        '{1'b1, 16'h9002, 8'h02, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 16'h8000, 8'h00, 18'h3C000, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 16'hC001, 8'h00, 18'h0A001, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 16'hA000, 8'h00, 18'h0E000, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 16'h9000, 8'h01, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 16'h7FFF, 8'h00, 18'h01FFF, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 slot 0 ignored
        '{1'b1, 16'h9002, 8'h01, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 16'h6ABC, 8'h00, 18'h00ABC, 1'b0, 1'b1, 1'b0, 4'd7},  // R7
        '{1'b0, 16'h8000, 8'h00, 18'h0A000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 16'hC000, 8'h00, 18'h3C000, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 16'hA002, 8'h1F, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b0, 16'hA000, 8'h00, 18'h3E000, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 16'h8003, 8'h3E, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, 16'h8000, 8'h00, 18'h3C000, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 high bit dropped
        '{1'b1, 16'h9001, 8'h02, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 16'h6000, 8'h00, 18'h00000, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 slot 1 ignored
        '{1'b0, 16'h4000, 8'h00, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [17:0] rom_addr;
    logic        rom_ce, ram_ce, open_bus, ext_sel_n;
    logic [16:0] rom_addr1;
    logic        rom_ce1, ram_ce1, open_bus1, ext_sel_n1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_prg_mapper u0 (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
        .cpu_wr (cpu_wr), .rom_addr (rom_addr), .rom_ce (rom_ce), .ram_ce (ram_ce),
        .open_bus (open_bus), .ext_sel_n (ext_sel_n)
    );

    // Second board wiring: index from A6 (low) and A7 (high), 16 banks
    banked_prg_mapper #(.ROM_BANKS (16), .IDX_LO_BIT (6), .IDX_HI_BIT (7)) u1 (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
        .cpu_wr (cpu_wr), .rom_addr (rom_addr1), .rom_ce (rom_ce1), .ram_ce (ram_ce1),
        .open_bus (open_bus1), .ext_sel_n (ext_sel_n1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
        #1;
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        cpu_wr   = 1'b0;
        #(CLK_PERIOD / 4);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset strobe", {31'd0, ext_sel_n}, 32'd1);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            if (VECS[i].is_wr) begin
                do_write(VECS[i].addr, VECS[i].data);
            end else begin
                do_read(VECS[i].addr);
                chk({tag, " rom_addr"}, {14'd0, rom_addr}, {14'd0, VECS[i].exp_addr});
                chk({tag, " rom_ce"}, {31'd0, rom_ce}, {31'd0, VECS[i].exp_rom});
                chk({tag, " ram_ce"}, {31'd0, ram_ce}, {31'd0, VECS[i].exp_ram});
                chk({tag, " open_bus"}, {31'd0, open_bus}, {31'd0, VECS[i].exp_ob});
            end
        end

        // R11 and R7: enables during write cycles (RAM enabled, first select = 30)
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_data = 8'h1E; cpu_wr = 1'b1;
        #2;
        chk("R11 rom_ce on write", {31'd0, rom_ce}, 32'd0);
        cpu_addr = 16'h6010;
        #2;
        chk("R7 ram_ce on write", {31'd0, ram_ce}, 32'd1);
        chk("R7 open_bus on write", {31'd0, open_bus}, 32'd0);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R10: data on the bus with cpu_wr low loads nothing
        cpu_addr = 16'h8000; cpu_data = 8'h11;
        @(negedge clk);
        do_read(16'h8000);
        chk("R10 no write without cpu_wr", {14'd0, rom_addr}, 32'h3C000);

        // R9: strobe follows a write to slot 3 for one cycle
        do_write(16'h9003, 8'h00);
        chk("R9 strobe low", {31'd0, ext_sel_n}, 32'd0);
        @(negedge clk);
        chk("R9 strobe released", {31'd0, ext_sel_n}, 32'd1);
        do_write(16'h9002, 8'h01);
        chk("R9 no strobe on slot 2", {31'd0, ext_sel_n}, 32'd1);

        // R1: reset in mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(16'h8000);
        chk("R1 first select cleared", {14'd0, rom_addr}, 32'h00000);
        do_read(16'hA000);
        chk("R1 second select cleared", {14'd0, rom_addr}, 32'h00000);
        do_read(16'hC000);
        chk("R1 swap cleared", {14'd0, rom_addr}, 32'h3C000);
        do_read(16'h6000);
        chk("R1 ram disabled", {31'd0, open_bus}, 32'd1);

        // R8: second wiring, 16 banks (second-last = 14)
        do_write(16'h9002, 8'h03);   // slot 0 for A6/A7 wiring
        do_read(16'h6000);
        chk("R8 slot 0 on A6/A7 ignored", {31'd0, open_bus1}, 32'd1);
        do_write(16'h9080, 8'h03);   // A7=1, A6=0 -> slot 2
        do_read(16'h8000);
        chk("R8 swap via A6/A7 slot 2", {15'd0, rom_addr1}, 32'h1C000);
        do_read(16'h6000);
        chk("R8 ram enable via A6/A7 slot 2", {31'd0, ram_ce1}, 32'd1);
        do_write(16'h90C0, 8'h00);   // slot 3
        chk("R8 strobe via A6/A7 slot 3", {31'd0, ext_sel_n1}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule